// File: doc/BRIEF.md
# Append-Only Wiper Store Manager

This block keeps the non-volatile side of a digital rheostat's wiper setting. It owns a small array of one-time-programmable words, modelled as registers, with room for a fixed number of stored wiper positions and two read-only factory tolerance words. A command decoder drives single-cycle request strobes into it. A store appends the current wiper value to the next unused slot. The append is followed by a long program interval, counted in clock cycles, during which the block is busy and ignores every request. A refresh sends the most recently stored value to the wiper register, or midscale when nothing has been stored. A location read returns the word at a 6-bit address. A last-address query returns how many slots are in use.

Leaving reset runs a restore sequence. The wiper is first loaded with midscale and then with the newest stored value. A warm reset keeps the array. A separate blank-array input returns the model to its unprogrammed state and stands for a part that has never been programmed.

Top module: `wiper_store_mgr`

## Requirements
- R1: After `rst_n` is released, `wiper_load` is high in two consecutive cycles. The first carries midscale (2^(DATA_W-1), 512 by default). The second carries the newest stored word, or midscale if the array is blank. `busy` is high from reset until the second load, and `wiper_val` holds midscale while reset is asserted.
- R2: A store request taken while idle, with `prog_en`=1 and at least one free slot, raises `busy` in the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles.
- R3: Accepted stores fill the slots in order. The k-th stored word is readable at address k (0x01 first, 0x32 last by default).
- R4: Any store request taken while idle clears `prog_ok` in the next cycle. `prog_ok` is set only in the cycle where a program completes with a write.
- R5: A store request with `prog_en`=0 performs no write and does not raise `busy`.
- R6: Once all N_SLOTS slots are used, a store request performs no write, does not raise `busy`, and leaves `prog_ok` at 0. The slot count never exceeds N_SLOTS.
- R7: While `busy` is high, store, refresh, read and last-address requests have no effect on `rd_data`, `last_addr`, `wiper_load` or the slot count.
- R8: A refresh request taken while idle gives `wiper_load`=1 in the next cycle. `wiper_val` is then the newest stored word, or midscale when the array is blank.
- R9: A read request taken while idle updates `rd_data` in the next cycle. A programmed slot returns its word. Address 0x39 returns TOL_HI and 0x3A returns TOL_LO. Address 0x00, unprogrammed slots and every other address return 0.
- R10: A last-address request taken while idle sets `last_addr` in the next cycle to the number of used slots, in binary (0 when blank, 0x32 when full).
- R11: Refresh, read and last-address requests arriving in the same cycle as an accepted store are answered from the state before that store.
- R12: `rst_n` leaves the stored slots intact. Only `blank_n` low returns the array to zero used slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low warm reset; starts the restore sequence |
| blank_n | input | 1 | Synchronous active-low return of the array model to the unprogrammed state |
| store_req | input | 1 | Strobe: append `req_data` to the next free slot |
| refresh_req | input | 1 | Strobe: load the wiper from the newest slot |
| rd_req | input | 1 | Strobe: read the word at `req_addr` |
| last_req | input | 1 | Strobe: report the number of used slots |
| prog_en | input | 1 | Program enable from the control register |
| req_addr | input | ADDR_W | Read address |
| req_data | input | DATA_W | Wiper value to store |
| busy | output | 1 | Restore or program in progress; requests ignored |
| prog_ok | output | 1 | Last program completed with a write |
| rd_data | output | DATA_W | Result of the last read |
| last_addr | output | ADDR_W | Result of the last last-address query |
| wiper_load | output | 1 | One-cycle load strobe for the wiper register |
| wiper_val | output | DATA_W | Value for the wiper register |

## Verification
The overlap that matters is a store being accepted in the same cycle as a refresh and a last-address query. The bench raises all three strobes on one edge. It expects the refresh to deliver the previously newest word and the count to show the old number of slots, while `busy` rises and `prog_ok` drops together. A second overlap is forced by raising every strobe in the middle of a program interval. The bench then checks that no wiper load appears and that the read and count results stay unchanged. A later count query must show that the extra store was never appended.

// File: rtl/wsm_pkg.sv
// Package: shared state encoding and fixed address constants of the
// wiper store manager. Assumes a 6-bit address space for reads.
package wsm_pkg;

    typedef enum logic [1:0] {
        ST_PRESET  = 2'd0,
        ST_RESTORE = 2'd1,
        ST_IDLE    = 2'd2,
        ST_PROG    = 2'd3
    } wsm_state_t;

    // Read addresses of the two factory tolerance words.
    localparam int TOL_HI_ADDR = 57;  // 0x39
    localparam int TOL_LO_ADDR = 58;  // 0x3A

endpackage

// File: rtl/wsm_slot_array.sv
// Module: register model of the append-only slot array.
// Holds N_SLOTS words plus a used-slot count. A write always lands in the
// slot indexed by the count, then the count grows by one. Reads of a slot
// beyond the count return zero. Assumes wr_en is a single-cycle pulse and
// that the caller never writes when full is high.
module wsm_slot_array
    import wsm_pkg::*;
#(
    parameter int N_SLOTS = 50,
    parameter int DATA_W  = 10,
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = $clog2(N_SLOTS + 1),
    parameter logic [DATA_W-1:0] TOL_HI = 10'h00A,
    parameter logic [DATA_W-1:0] TOL_LO = 10'h0B0
) (
    input  logic              clk,
    input  logic              blank_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] latest,
    output logic [CNT_W-1:0]  fill,
    output logic              full
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    logic [CNT_W-1:0]  fill_q;
    logic [DATA_W-1:0] slot_w [N_SLOTS];

    // Used-slot count: cleared only by the blank input, grows by one per write.
    always_ff @(posedge clk) begin
        if (!blank_n) begin
            fill_q <= '0;
        end else if (wr_en && !full) begin
            fill_q <= fill_q + CNT_W'(1);
        end
    end

    // One storage word per slot; each captures data only when it is next.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        logic [DATA_W-1:0] word_q;

        // Slot capture: written once, when the count points at this slot.
        always_ff @(posedge clk) begin
            if (wr_en && !full && fill_q == CNT_W'(i)) begin
                word_q <= wr_data;
            end
        end

        assign slot_w[i] = word_q;
    end

    assign fill = fill_q;
    assign full = (int'(fill_q) >= N_SLOTS);

    // Read decode: programmed slots, tolerance words, zero elsewhere.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (int'(rd_addr) == i + 1 && i < int'(fill_q)) begin
                rd_word = slot_w[i];
            end
        end
        if (int'(rd_addr) == TOL_HI_ADDR) begin
            rd_word = TOL_HI;
        end else if (int'(rd_addr) == TOL_LO_ADDR) begin
            rd_word = TOL_LO;
        end
    end

    // Newest stored word, or midscale for a blank array.
    always_comb begin
        latest = MID;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (int'(fill_q) == i + 1) begin
                latest = slot_w[i];
            end
        end
    end

endmodule

// File: rtl/wsm_prog_timer.sv
// Module: program-interval timer. A start pulse arms it for PROG_CYCLES
// cycles; done is high in the last of them. Assumes PROG_CYCLES >= 1 and
// that start never arrives while the timer runs.
module wsm_prog_timer #(
    parameter int PROG_CYCLES = 35_000_000,
    parameter int TMR_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    logic [TMR_W-1:0] cnt_q;
    logic             run_q;

    // Countdown: load on start, step down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= TMR_W'(PROG_CYCLES - 1);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - TMR_W'(1);
            end
        end
    end

    assign done = run_q && (cnt_q == '0);

endmodule

// File: rtl/wsm_ctrl.sv
// Module: sequencer of the store manager. It runs the two-step restore
// after reset, then serves request strobes while idle, and holds a
// program interval after each accepted store. Same-cycle requests are
// answered from the array state before the store. Assumes strobes are
// single-cycle and that the array's outputs are combinational.
module wsm_ctrl
    import wsm_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic              refresh_req,
    input  logic              rd_req,
    input  logic              last_req,
    input  logic              prog_en,
    input  logic [DATA_W-1:0] req_data,
    input  logic              full,
    input  logic [CNT_W-1:0]  fill,
    input  logic [DATA_W-1:0] latest,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              tmr_done,
    output logic              tmr_start,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              prog_ok,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] last_addr,
    output logic              wiper_load,
    output logic [DATA_W-1:0] wiper_val,
    output wsm_state_t        st
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    wsm_state_t        st_q;
    logic [DATA_W-1:0] pend_q;
    logic              accept;

    assign accept    = (st_q == ST_IDLE) && store_req && prog_en && !full;
    assign tmr_start = accept;
    assign wr_en     = (st_q == ST_PROG) && tmr_done;
    assign wr_data   = pend_q;
    assign busy      = (st_q != ST_IDLE);
    assign st        = st_q;

    // State and outputs: restore steps, request service, program wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_PRESET;
            wiper_load <= 1'b0;
            wiper_val  <= MID;
            prog_ok    <= 1'b0;
            rd_data    <= '0;
            last_addr  <= '0;
            pend_q     <= '0;
        end else begin
            wiper_load <= 1'b0;
            case (st_q)
                ST_PRESET: begin
                    wiper_load <= 1'b1;
                    wiper_val  <= MID;
                    st_q       <= ST_RESTORE;
                end
                ST_RESTORE: begin
                    wiper_load <= 1'b1;
                    wiper_val  <= latest;
                    st_q       <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (refresh_req) begin
                        wiper_load <= 1'b1;
                        wiper_val  <= latest;
                    end
                    if (rd_req) begin
                        rd_data <= rd_word;
                    end
                    if (last_req) begin
                        last_addr <= ADDR_W'(fill);
                    end
                    if (store_req) begin
                        prog_ok <= 1'b0;
                    end
                    if (accept) begin
                        pend_q <= req_data;
                        st_q   <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (tmr_done) begin
                        prog_ok <= 1'b1;
                        st_q    <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wiper_store_mgr.sv
// Module: top of the append-only wiper store manager. It ties the
// sequencer, the program timer and the slot array together. Assumes one
// clock domain, request strobes synchronous to clk, and blank_n used only
// to model a never-programmed part.
module wiper_store_mgr
    import wsm_pkg::*;
#(
    parameter int N_SLOTS     = 50,
    parameter int DATA_W      = 10,
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 35_000_000,
    parameter logic [DATA_W-1:0] TOL_HI = 10'h00A,
    parameter logic [DATA_W-1:0] TOL_LO = 10'h0B0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_n,
    input  logic              store_req,
    input  logic              refresh_req,
    input  logic              rd_req,
    input  logic              last_req,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              prog_ok,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] last_addr,
    output logic              wiper_load,
    output logic [DATA_W-1:0] wiper_val
);

    localparam int CNT_W = $clog2(N_SLOTS + 1);

    logic              tmr_start;
    logic              tmr_done;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] latest;
    logic [CNT_W-1:0]  fill;
    logic              full;
    wsm_state_t        st;

    wsm_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_req   (store_req),
        .refresh_req (refresh_req),
        .rd_req      (rd_req),
        .last_req    (last_req),
        .prog_en     (prog_en),
        .req_data    (req_data),
        .full        (full),
        .fill        (fill),
        .latest      (latest),
        .rd_word     (rd_word),
        .tmr_done    (tmr_done),
        .tmr_start   (tmr_start),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .busy        (busy),
        .prog_ok     (prog_ok),
        .rd_data     (rd_data),
        .last_addr   (last_addr),
        .wiper_load  (wiper_load),
        .wiper_val   (wiper_val),
        .st          (st)
    );

    wsm_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    wsm_slot_array #(
        .N_SLOTS (N_SLOTS),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .TOL_HI  (TOL_HI),
        .TOL_LO  (TOL_LO)
    ) u_arr (
        .clk     (clk),
        .blank_n (blank_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_addr (req_addr),
        .rd_word (rd_word),
        .latest  (latest),
        .fill    (fill),
        .full    (full)
    );

endmodule

// File: rtl/wsm_checker.sv
// Module: property checker for wiper_store_mgr, attached by bind. It keeps
// its own program-window counter so that the interval length is checked
// without deep history. Assumes the top's internal names fill and st.
module wsm_checker
    import wsm_pkg::*;
#(
    parameter int N_SLOTS     = 50,
    parameter int DATA_W      = 10,
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 35_000_000,
    parameter int CNT_W       = $clog2(N_SLOTS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank_n,
    input logic              store_req,
    input logic              refresh_req,
    input logic              last_req,
    input logic              prog_en,
    input logic              busy,
    input logic              prog_ok,
    input logic [ADDR_W-1:0] last_addr,
    input logic              wiper_load,
    input logic [DATA_W-1:0] wiper_val,
    input logic [CNT_W-1:0]  fill,
    input wsm_state_t        st
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    int unsigned ck_cnt;

    // Expected program window, counted from accepted stores at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cnt <= 0;
        end else if (ck_cnt != 0) begin
            ck_cnt <= ck_cnt - 1;
        end else if (!busy && store_req && prog_en && int'(fill) < N_SLOTS) begin
            ck_cnt <= PROG_CYCLES;
        end
    end

    a_r1_preset_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRESET) |=> (wiper_load && wiper_val == MID));

    a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cnt != 0) |-> busy);

    a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cnt == 1) |=> !busy);

    a_r3_fill_step: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        (fill != $past(fill) && $past(blank_n)) |-> (int'(fill) == int'($past(fill)) + 1));

    a_r4_ok_after_write: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        ($rose(prog_ok) && $past(blank_n)) |-> (int'(fill) == int'($past(fill)) + 1));

    a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && store_req && !prog_en) |=> (!busy && !prog_ok));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) <= N_SLOTS);

    a_r6_full_reject: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        (!busy && store_req && int'(fill) == N_SLOTS) |=> (!busy && !prog_ok));

    a_r7_quiet_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> !wiper_load);

    a_r8_refresh_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && refresh_req) |=> wiper_load);

    a_r10_last_addr: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        (!busy && last_req) |=> (int'(last_addr) == int'($past(fill))));

endmodule

bind wiper_store_mgr wsm_checker #(
    .N_SLOTS     (N_SLOTS),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blank_n     (blank_n),
    .store_req   (store_req),
    .refresh_req (refresh_req),
    .last_req    (last_req),
    .prog_en     (prog_en),
    .busy        (busy),
    .prog_ok     (prog_ok),
    .last_addr   (last_addr),
    .wiper_load  (wiper_load),
    .wiper_val   (wiper_val),
    .fill        (fill),
    .st          (st)
);

// File: tb/sim_wiper_store_mgr.sv
// Bench: drives strobes on falling edges, samples on the next falling edge,
// keeps an arithmetic model of the slot array and sweeps every address.
module sim_wiper_store_mgr;

    localparam int P   = 5;
    localparam int N   = 50;
    localparam int DW  = 10;
    localparam int AW  = 6;
    localparam int MID = 512;
    localparam logic [DW-1:0] THI = 10'h00A;
    localparam logic [DW-1:0] TLO = 10'h0B0;

    logic          clk = 1'b0;
    logic          rst_n, blank_n;
    logic          store_req, refresh_req, rd_req, last_req, prog_en;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          busy, prog_ok, wiper_load;
    logic [DW-1:0] rd_data, wiper_val;
    logic [AW-1:0] last_addr;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_fill = 0;
    int exp_slot [N];

    wiper_store_mgr #(
        .N_SLOTS (N), .DATA_W (DW), .ADDR_W (AW),
        .PROG_CYCLES (P), .TOL_HI (THI), .TOL_LO (TLO)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .blank_n (blank_n),
        .store_req (store_req), .refresh_req (refresh_req),
        .rd_req (rd_req), .last_req (last_req), .prog_en (prog_en),
        .req_addr (req_addr), .req_data (req_data),
        .busy (busy), .prog_ok (prog_ok), .rd_data (rd_data),
        .last_addr (last_addr), .wiper_load (wiper_load), .wiper_val (wiper_val)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_latest();
        return (exp_fill == 0) ? MID : exp_slot[exp_fill-1];
    endfunction

    function automatic int exp_read(input int a);
        if (a >= 1 && a <= exp_fill) return exp_slot[a-1];
        if (a == 57) return int'(THI);
        if (a == 58) return int'(TLO);
        return 0;
    endfunction

    // Raise the chosen strobes for one clock, then lower them.
    task automatic strobe(input bit s, input bit r, input bit d, input bit l,
                          input int a, input int v);
        @(negedge clk);
        store_req = s; refresh_req = r; rd_req = d; last_req = l;
        req_addr = AW'(a); req_data = DW'(v);
        @(negedge clk);
        store_req = 0; refresh_req = 0; rd_req = 0; last_req = 0;
    endtask

    // Wait out a program interval; optionally fire every strobe inside it.
    task automatic wait_prog(input bit hammer, output int cyc, output bit saw_load);
        cyc = 0; saw_load = 0;
        while (busy) begin
            if (wiper_load) saw_load = 1;
            if (hammer && cyc == 1) begin
                store_req = 1; refresh_req = 1; rd_req = 1; last_req = 1;
                req_addr = 6'h39; req_data = 10'h001;
            end else begin
                store_req = 0; refresh_req = 0; rd_req = 0; last_req = 0;
            end
            cyc++;
            @(negedge clk);
        end
        store_req = 0; refresh_req = 0; rd_req = 0; last_req = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        summary();
    end

    initial begin
        int cyc;
        bit saw;
        rst_n = 0; blank_n = 0; prog_en = 0;
        store_req = 0; refresh_req = 0; rd_req = 0; last_req = 0;
        req_addr = '0; req_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy in reset", int'(busy), 1);
        chk("R1 preset in reset", int'(wiper_val), MID);
        chk("R1 no load in reset", int'(wiper_load), 0);
        rst_n = 1; blank_n = 1;
        @(negedge clk);
        chk("R1 first load", int'(wiper_load), 1);
        chk("R1 first value", int'(wiper_val), MID);
        chk("R1 busy during restore", int'(busy), 1);
        @(negedge clk);
        chk("R1 second load", int'(wiper_load), 1);
        chk("R1 blank restore value", int'(wiper_val), MID);
        chk("R1 idle after restore", int'(busy), 0);
        @(negedge clk);
        chk("R1 load ends", int'(wiper_load), 0);

        // R10: blank count; R9: blank sweep
        strobe(0, 0, 0, 1, 0, 0);
        chk("R10 blank count", int'(last_addr), 0);
        for (int a = 0; a < 64; a++) begin
            strobe(0, 0, 1, 0, a, 0);
            chk($sformatf("R9 blank read 0x%0h", a), int'(rd_data), exp_read(a));
        end
        // R8: refresh of a blank array
        strobe(0, 1, 0, 0, 0, 0);
        chk("R8 refresh load", int'(wiper_load), 1);
        chk("R8 refresh midscale", int'(wiper_val), MID);

        // R5: store without program enable
        strobe(1, 0, 0, 0, 0, 10'h155);
        chk("R5 no busy", int'(busy), 0);
        chk("R5 no success", int'(prog_ok), 0);
        strobe(0, 0, 0, 1, 0, 0);
        chk("R5 count unchanged", int'(last_addr), 0);

        // R2 R3 R4: first store
        prog_en = 1;
        strobe(1, 0, 0, 0, 0, 10'h100);
        chk("R4 cleared at accept", int'(prog_ok), 0);
        wait_prog(0, cyc, saw);
        chk("R2 busy length", cyc, P);
        chk("R4 success set", int'(prog_ok), 1);
        exp_slot[exp_fill] = 10'h100; exp_fill++;
        strobe(0, 0, 1, 0, 1, 0);
        chk("R3 slot 1 word", int'(rd_data), 10'h100);

        // R7: every strobe during a program interval
        strobe(1, 0, 0, 0, 0, 10'h2AA);
        wait_prog(1, cyc, saw);
        chk("R7 no wiper load", int'(saw), 0);
        chk("R7 read result kept", int'(rd_data), 10'h100);
        chk("R7 count result kept", int'(last_addr), 0);
        chk("R2 busy length hammered", cyc, P);
        exp_slot[exp_fill] = 10'h2AA; exp_fill++;
        strobe(0, 0, 0, 1, 0, 0);
        chk("R7 extra store not appended", int'(last_addr), 2);

        // R11: store, refresh and count in one cycle
        strobe(1, 1, 0, 1, 0, 10'h3FF);
        chk("R11 refresh sees old newest", int'(wiper_val), exp_latest());
        chk("R11 refresh strobe", int'(wiper_load), 1);
        chk("R11 count before store", int'(last_addr), 2);
        chk("R11 store accepted", int'(busy), 1);
        chk("R4 cleared with overlap", int'(prog_ok), 0);
        wait_prog(0, cyc, saw);
        exp_slot[exp_fill] = 10'h3FF; exp_fill++;

        // R3: fill to capacity with computed data
        while (exp_fill < N) begin
            int v = (exp_fill * 37 + 5) % 1024;
            strobe(1, 0, 0, 0, 0, v);
            wait_prog(0, cyc, saw);
            chk("R2 busy length fill", cyc, P);
            exp_slot[exp_fill] = v; exp_fill++;
        end
        strobe(0, 0, 0, 1, 0, 0);
        chk("R10 full count", int'(last_addr), N);
        for (int a = 0; a < 64; a++) begin
            strobe(0, 0, 1, 0, a, 0);
            chk($sformatf("R9 R3 full read 0x%0h", a), int'(rd_data), exp_read(a));
        end
        strobe(0, 1, 0, 0, 0, 0);
        chk("R8 refresh newest", int'(wiper_val), exp_latest());

        // R6: store when full
        strobe(1, 0, 0, 0, 0, 10'h011);
        chk("R6 no busy when full", int'(busy), 0);
        chk("R6 success low when full", int'(prog_ok), 0);
        strobe(0, 0, 0, 1, 0, 0);
        chk("R6 count stays", int'(last_addr), N);
        strobe(0, 0, 1, 0, N, 0);
        chk("R6 last slot intact", int'(rd_data), exp_slot[N-1]);

        // R12 R1: warm reset keeps the array and restores newest
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 preset on warm reset", int'(wiper_val), MID);
        rst_n = 1;
        @(negedge clk);
        chk("R1 warm first value", int'(wiper_val), MID);
        @(negedge clk);
        chk("R12 warm restore newest", int'(wiper_val), exp_latest());
        chk("R1 warm second load", int'(wiper_load), 1);
        strobe(0, 0, 1, 0, 1, 0);
        chk("R12 slot 1 kept", int'(rd_data), exp_slot[0]);

        // R12: blank input empties the array
        @(negedge clk); blank_n = 0;
        @(negedge clk); blank_n = 1;
        exp_fill = 0;
        strobe(0, 0, 0, 1, 0, 0);
        chk("R12 blank count", int'(last_addr), 0);
        strobe(0, 1, 0, 0, 0, 0);
        chk("R12 blank refresh", int'(wiper_val), MID);
        strobe(0, 0, 1, 0, 1, 0);
        chk("R12 blank read", int'(rd_data), 0);

        summary();
    end

endmodule